// File: doc/BRIEF.md
# Three-Multiplier Complex Rotator

This block rotates a complex fixed-point sample `x + jy` by a coefficient `C + jS`, where C and S are the quantized cosine and sine of an angle. It is meant to sit between the stages of a pipelined FFT. The surrounding control supplies one coefficient set per sample from a lookup table. Each set carries three words: C, the sum C+S and the difference S−C. All three are prepared in advance, so the block never adds coefficients itself.

The sum x+y is formed first, in one bit more than the data width. One product, the shared term k = C·(x+y), serves both outputs. Two more products complete the rotation: X = k − y·(C+S) and Y = k + x·(S−C). That makes three real multipliers in place of four. The exact integer results are rounded to the data width and saturated. They leave a three-stage pipeline with a valid flag that travels in step with the data.

All values are two's complement. The coefficients have `FRAC` fractional bits, so 1.0 is coded as 2^FRAC.

Top module: `cplx_rot3`

## Requirements
- R1: For each valid input, the outputs are X = xC − yS and Y = yC + xS, computed as exact integers at FRAC fractional bits and then rounded and saturated. Here S = in_cps − in_c, and in_smc equals S − C.
- R2: Rounding is to nearest, with ties going towards plus infinity. The result is floor((v + 2^(FRAC−1)) / 2^FRAC).
- R3: A rounded result above 2^(DW−1)−1 is output as 2^(DW−1)−1. A rounded result below −2^(DW−1) is output as −2^(DW−1).
- R4: out_valid is in_valid delayed by exactly 3 clock cycles. The data on out_x and out_y belongs to the sample presented 3 cycles earlier.
- R5: While rst (synchronous, active high) is asserted, out_valid, out_x and out_y are all zero from the next clock edge onwards.
- R6: With C = 2^FRAC, C+S = 2^FRAC and S−C = −2^FRAC (angle 0), the output equals the input exactly.
- R7: With C = 0, C+S = 2^FRAC and S−C = 2^FRAC (angle π/2), the output is Y = x and X = −y, saturated.
- R8: The sum x+y cannot overflow before the multiplication. At angle 0 with x = y = 2^(DW−1)−1, or with x = y = −2^(DW−1), the sample passes through unchanged.
- R9: In a cycle where out_valid is low, out_x and out_y hold their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample is valid |
| in_x | input | DW | Real part of the input |
| in_y | input | DW | Imaginary part of the input |
| in_c | input | CW | Coefficient C |
| in_cps | input | CW | Coefficient sum C+S |
| in_smc | input | CW | Coefficient difference S−C |
| out_valid | output | 1 | Output sample is valid |
| out_x | output | DW | Real part of the rotated result |
| out_y | output | DW | Imaginary part of the rotated result |

## Verification
The bench uses the defaults DW = 16, CW = 16 and FRAC = 14. With these values 1.0 is coded as 16384, and the coefficient sum near π/4 (about 23170) fits in the coefficient word. Full-scale 16-bit data then drives the rotated magnitude past the output range at π/4 and at π/2. The same data stresses the 17-bit pre-adder at angle 0. Half-LSB coefficients such as 0.5 and 0.5 − 2^−14 expose the direction of rounding on ties. The results are compared against a four-product integer model, for random samples at 64 evenly spaced angles with random idle gaps.

// File: rtl/cplx_rot3.sv
module cplx_rot3 #(
  parameter int DW   = 16,
  parameter int CW   = 16,
  parameter int FRAC = 14
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_x,
  input  logic signed [DW-1:0] in_y,
  input  logic signed [CW-1:0] in_c,
  input  logic signed [CW-1:0] in_cps,
  input  logic signed [CW-1:0] in_smc,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_x,
  output logic signed [DW-1:0] out_y
);
  localparam int SW = DW + 1;
  localparam int PW = SW + CW;
  localparam int RW = PW + 1;
  localparam logic signed [RW-1:0] HALF = RW'(1) <<< (FRAC - 1);
  localparam logic signed [RW-1:0] MAXR = {{(RW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [RW-1:0] MINR = {{(RW-DW+1){1'b1}}, {(DW-1){1'b0}}};

  logic                 v1, v2;
  logic signed [DW-1:0] x1, y1;
  logic signed [SW-1:0] s1;
  logic signed [CW-1:0] c1, cps1, smc1;
  logic signed [PW-1:0] k2, py2, px2;
  logic signed [RW-1:0] sum_x, sum_y, rnd_x, rnd_y;

  function automatic logic signed [DW-1:0] clip(input logic signed [RW-1:0] v);
    if (v > MAXR)      return MAXR[DW-1:0];
    else if (v < MINR) return MINR[DW-1:0];
    else               return v[DW-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0; v2 <= 1'b0; out_valid <= 1'b0;
      x1 <= '0; y1 <= '0; s1 <= '0; c1 <= '0; cps1 <= '0; smc1 <= '0;
      k2 <= '0; py2 <= '0; px2 <= '0;
      out_x <= '0; out_y <= '0;
    end else begin
      v1 <= in_valid;
      v2 <= v1;
      out_valid <= v2;
      if (in_valid) begin
        x1   <= in_x;
        y1   <= in_y;
        s1   <= SW'(in_x) + SW'(in_y);
        c1   <= in_c;
        cps1 <= in_cps;
        smc1 <= in_smc;
      end
      if (v1) begin
        k2  <= PW'(c1) * PW'(s1);
        py2 <= PW'(y1) * PW'(cps1);
        px2 <= PW'(x1) * PW'(smc1);
      end
      if (v2) begin
        out_x <= clip(rnd_x);
        out_y <= clip(rnd_y);
      end
    end
  end

  assign sum_x = RW'(k2) - RW'(py2);
  assign sum_y = RW'(k2) + RW'(px2);
  assign rnd_x = (sum_x + HALF) >>> FRAC;
  assign rnd_y = (sum_y + HALF) >>> FRAC;
endmodule

// File: rtl/cplx_rot3_chk.sv
module cplx_rot3_chk #(
  parameter int DW   = 16,
  parameter int CW   = 16,
  parameter int FRAC = 14
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic signed [DW-1:0] in_x,
  input logic signed [DW-1:0] in_y,
  input logic signed [CW-1:0] in_c,
  input logic signed [CW-1:0] in_cps,
  input logic signed [CW-1:0] in_smc,
  input logic                 out_valid,
  input logic signed [DW-1:0] out_x,
  input logic signed [DW-1:0] out_y
);
  localparam logic signed [CW-1:0] ONE = CW'(1) <<< FRAC;
  localparam logic signed [CW-1:0] NEG = -ONE;

  logic [1:0] since;
  always_ff @(posedge clk)
    if (rst) since <= 2'd0;
    else if (since != 2'd3) since <= since + 2'd1;

  a_r4_valid_latency: assert property (@(posedge clk) disable iff (rst)
    since == 2'd3 |-> out_valid == $past(in_valid, 3));

  a_r5_reset_idle: assert property (@(posedge clk)
    rst |=> !out_valid && out_x == '0 && out_y == '0);

  a_r6_identity: assert property (@(posedge clk) disable iff (rst)
    since == 2'd3 && $past(in_valid, 3) && $past(in_c, 3) == ONE &&
    $past(in_cps, 3) == ONE && $past(in_smc, 3) == NEG
    |-> out_x == $past(in_x, 3) && out_y == $past(in_y, 3));

  a_r7_quarter_turn: assert property (@(posedge clk) disable iff (rst)
    since == 2'd3 && $past(in_valid, 3) && $past(in_c, 3) == '0 &&
    $past(in_cps, 3) == ONE && $past(in_smc, 3) == ONE
    |-> out_y == $past(in_x, 3));

  a_r9_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_x) && $stable(out_y));
endmodule

bind cplx_rot3 cplx_rot3_chk #(.DW(DW), .CW(CW), .FRAC(FRAC)) u_chk (.*);

// File: tb/test_cplx_rot3.sv
module test_cplx_rot3;
  localparam int DW = 16, CW = 16, FRAC = 14;
  localparam int CLK_PERIOD = 10;
  localparam int ONE = 1 << FRAC;

  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0;
  logic signed [DW-1:0] in_x = '0, in_y = '0, out_x, out_y;
  logic signed [CW-1:0] in_c = '0, in_cps = '0, in_smc = '0;
  logic out_valid;

  cplx_rot3 #(.DW(DW), .CW(CW), .FRAC(FRAC)) i_cplx_rot3 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_x(in_x), .in_y(in_y),
    .in_c(in_c), .in_cps(in_cps), .in_smc(in_smc),
    .out_valid(out_valid), .out_x(out_x), .out_y(out_y));

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_cmp = 0, n_bad = 0;
  longint q_x[$], q_y[$];
  int q_t[$];
  string q_tag[$];
  logic seen = 1'b0;
  logic signed [DW-1:0] last_x, last_y;

  task automatic check(input string tag, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic longint rnd_sat(input longint v);
    longint r = (v + (64'sd1 <<< (FRAC-1))) >>> FRAC;
    longint hi = (64'sd1 <<< (DW-1)) - 1;
    longint lo = -(64'sd1 <<< (DW-1));
    if (r > hi) return hi;
    if (r < lo) return lo;
    return r;
  endfunction

  task automatic send(input longint x, input longint y, input longint c,
                      input longint s, input string tag);
    @(negedge clk);
    in_valid = 1'b1;
    in_x = DW'(x); in_y = DW'(y);
    in_c = CW'(c); in_cps = CW'(c + s); in_smc = CW'(s - c);
    q_x.push_back(rnd_sat(x*c - y*s));
    q_y.push_back(rnd_sat(y*c + x*s));
    q_t.push_back(cyc);
    q_tag.push_back(tag);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid) begin
        if (q_t.size() == 0) check("R4 unexpected out_valid", 1, 0);
        else begin
          string tg = q_tag.pop_front();
          check({tg, " R4 latency"}, cyc - q_t.pop_front(), 3);
          check({tg, " X"}, out_x, q_x.pop_front());
          check({tg, " Y"}, out_y, q_y.pop_front());
        end
        last_x = out_x; last_y = out_y; seen = 1'b1;
      end else if (seen) begin
        check("R9 hold X", out_x, last_x);
        check("R9 hold Y", out_y, last_y);
      end
    end
  end

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R5 reset valid", out_valid, 0);
    check("R5 reset X", out_x, 0);
    check("R5 reset Y", out_y, 0);
    rst = 1'b0;

    send(1234, -567, ONE, 0, "R6 angle0");
    send(32767, 32767, ONE, 0, "R8 max preadd");
    send(-32768, -32768, ONE, 0, "R8 min preadd");
    idle(2);
    send(1000, 2000, 0, ONE, "R7 quarter");
    send(5, -32768, 0, ONE, "R7 R3 quarter sat");
    send(-32768, -32768, 11585, 11585, "R3 eighth sat");
    send(32767, 32767, 11585, 11585, "R3 eighth sat high");
    send(-32768, 100, -ONE, 0, "R3 half turn");
    idle(1);
    send(1, 0, 8192, 0, "R2 tie up");
    send(1, 0, 8191, 0, "R2 below tie");
    send(-1, 0, 8192, 0, "R2 negative tie");
    send(3, -3, 8192, 0, "R2 odd halves");
    idle(3);

    for (int i = 0; i < 300; i++) begin
      int k = $urandom_range(0, 63);
      real a = k * 6.283185307179586 / 64.0;
      longint c = longint'(int'($cos(a) * ONE));
      longint s = longint'(int'($sin(a) * ONE));
      longint x = longint'(shortint'($urandom));
      longint y = longint'(shortint'($urandom));
      send(x, y, c, s, "R1 random");
      if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
    end
    idle(6);
    check("R4 queue drained", q_t.size(), 0);
    report();
  end
endmodule